// File: doc/BRIEF.md
# Timestamp-Driven Reciprocal Phase-Locked Loop

This block tracks the phase and frequency of a local periodic update tick against an external reference clock. The only view it has of the reference is a stream of 32-bit capture-counter values. These are quantized and may carry a count or so of jitter. The capture counter runs 2^DT2 times faster than the update tick.

On each tick the block advances its phase accumulator. When a capture value comes with the tick, the block also runs two loops. The first is a frequency loop, which turns the measured reference period into a frequency estimate. The second is a phase loop, which trims that estimate by the phase error implied by the sub-tick offset of the capture.

The frequency word is unsigned. A value of 2^32 would mean the tick rate equals the reference rate. The phase word wraps at 2^32, which is one full reference turn.

A caller pulses the update strobe once per tick and supplies a capture value when one arrived during that tick. It also sets the two loop-settling shifts at run time. The 64-bit product of the frequency loop passes through a register pipeline. So each tick takes a fixed MUL_STAGES+1 clocks. During that time the block reports busy, and at the end it presents the new phase and frequency with a one-clock valid pulse.

Top module: `ts_rpll`

## Requirements
- R1: After reset, `ph_out` and `fr_out` read 0 and `busy` and `out_vld` are low; the stored capture value and both frequency estimates start at 0.
- R2: A strobe sampled while `busy` is low is accepted. `busy` is high from the next clock until the edge L = MUL_STAGES+1 clocks after the accepting edge. `out_vld` is high for exactly the one clock following that edge.
- R3: A strobe (with or without a capture value) sampled while `busy` is high has no effect on any later output.
- R4: Every accepted tick first adds the pre-tick total frequency to the phase, modulo 2^32. A tick without a capture value leaves both frequency estimates unchanged, so `fr_out` repeats its previous value.
- R5: With a capture value, the period is the capture minus the stored capture, modulo 2^32. The new capture then becomes the stored one, so periods are measured correctly across the 2^32 wrap.
- R6: The signal term is computed from the full 64-bit unsigned product of the frequency-loop estimate and the period. Add 2^(sf-1), shift right by sf and keep the low 32 bits, where sf is `shf_in` and must lie in [DT2, 32+DT2]. `shp_in` must lie in [DT2, DT2+31].
- R7: The frequency-loop estimate becomes itself plus 2^(32+DT2-sf) minus the signal term, modulo 2^32. The constant wraps to 0 when sf equals DT2.
- R8: The phase loop works from the capture c. It forms d = (2^32-c) mod 2^DT2 and an expected phase of (f_old >> DT2)*d modulo 2^32, using the pre-tick total frequency f_old. The expected phase minus the advanced phase is taken as a signed value and shifted right arithmetically by `shp_in`-DT2. The new total frequency is the new frequency-loop estimate plus that error.
- R9: Capture values come from a reference with period P counts (P > 2^DT2) and at most ±1 count of jitter. Under these, `fr_out` settles within 3% of 2^(32+DT2)/P.
- R10: `ts_vld` and `ts_in` have no effect unless they come with an accepted strobe.
- R11: `ph_out` and `fr_out` change only in a clock where `out_vld` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_stb | input | 1 | Update tick strobe |
| ts_vld | input | 1 | A capture value accompanies this tick |
| ts_in | input | 32 | Capture counter value of the latest reference edge |
| shf_in | input | SHW | Frequency-loop settling shift |
| shp_in | input | SHW | Phase-loop settling shift |
| busy | output | 1 | A tick is being computed; strobes are ignored |
| out_vld | output | 1 | One-clock pulse when new outputs appear |
| ph_out | output | 32 | Phase of the tick in units of 2^-32 reference turn |
| fr_out | output | 32 | Tick-to-reference frequency ratio in units of 2^-32 |

## Verification
The hardest conditions to reach from the ports are the extremes of the shift arithmetic. These include sf equal to DT2, where the reference constant wraps to zero, sf at 32+DT2, and a phase shift of 31. Also hard to reach are capture differences that cross the 2^32 boundary. The bench starts the reference counter just below the wrap and locks the loop first. It then sweeps every legal frequency shift against several phase shifts while a jittered reference keeps running. Every tick is compared bit for bit with an arithmetic model, so a wrong wrap, rounding or sign surfaces at once.

// File: rtl/ts_rpll_pkg.sv
package ts_rpll_pkg;
   localparam int WORD_W = 32;
   typedef logic [WORD_W-1:0]   word_t;
   typedef logic [2*WORD_W-1:0] dword_t;
endpackage

// File: rtl/ts_rpll_mul.sv
// Unsigned W x W multiplier with a register chain of STAGES stages.
module ts_rpll_mul #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [2*W-1:0] p
);
   localparam int PW = 2 * W;

   if (STAGES < 1) begin : g_bad_stages
      $error("ts_rpll_mul: STAGES must be at least 1");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [PW-1:0] q;
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= PW'(a) * PW'(b);
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= g_stage[s-1].q;
         end
      end
   end

   assign p = g_stage[STAGES-1].q;
endmodule

// File: rtl/ts_rpll_freq.sv
// Frequency loop: rounded signal term, reference constant, new estimate.
module ts_rpll_freq
   import ts_rpll_pkg::*;
#(
   parameter int DT2 = 4,
   parameter int SHW = 6
) (
   input  dword_t         prod,
   input  word_t          ff,
   input  logic [SHW-1:0] shf,
   output word_t          ff_nx
);
   localparam int TOP    = WORD_W + DT2;
   localparam int SUM_W  = 2 * WORD_W + 1;

   logic [SUM_W-1:0] bias, sum, shifted;
   word_t            sig_term, ref_term;
   logic [6:0]       ref_amt;

   always_comb begin
      bias     = SUM_W'(1) << (shf - SHW'(1));
      sum      = {1'b0, prod} + bias;
      shifted  = sum >> shf;
      sig_term = shifted[WORD_W-1:0];
      ref_amt  = 7'(TOP) - 7'(shf);
      if (int'(shf) > TOP) ref_term = '0;
      else                 ref_term = word_t'(dword_t'(1) << ref_amt);
      ff_nx    = ff + ref_term - sig_term;
   end
endmodule

// File: rtl/ts_rpll_phase.sv
// Phase loop: sub-tick offset, expected phase, shifted error, new total frequency.
module ts_rpll_phase
   import ts_rpll_pkg::*;
#(
   parameter int DT2 = 4,
   parameter int SHW = 6
) (
   input  word_t          cap,
   input  word_t          f_old,
   input  word_t          y_adv,
   input  word_t          ff_nx,
   input  logic [SHW-1:0] shp,
   output word_t          f_nx
);
   logic [DT2-1:0] off;
   word_t          neg_cap, exp_ph, err, corr;
   logic [SHW-1:0] sh_amt;

   always_comb begin
      neg_cap = word_t'(0) - cap;
      off     = neg_cap[DT2-1:0];
      exp_ph  = word_t'(f_old >> DT2) * word_t'(off);
      err     = exp_ph - y_adv;
      sh_amt  = shp - SHW'(DT2);
      corr    = word_t'($signed(err) >>> sh_amt);
      f_nx    = ff_nx + corr;
   end
endmodule

// File: rtl/ts_rpll.sv
module ts_rpll
   import ts_rpll_pkg::*;
#(
   parameter int DT2        = 4,
   parameter int MUL_STAGES = 2,
   parameter int SHW        = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           upd_stb,
   input  logic           ts_vld,
   input  logic [31:0]    ts_in,
   input  logic [SHW-1:0] shf_in,
   input  logic [SHW-1:0] shp_in,
   output logic           busy,
   output logic           out_vld,
   output logic [31:0]    ph_out,
   output logic [31:0]    fr_out
);
   localparam int LAT = MUL_STAGES + 1;
   localparam int CW  = $clog2(LAT + 1);

   if (DT2 < 1 || DT2 > 16) begin : g_bad_dt2
      $error("ts_rpll: DT2 must lie in 1..16");
   end
   if (MUL_STAGES < 1 || MUL_STAGES > 8) begin : g_bad_stages
      $error("ts_rpll: MUL_STAGES must lie in 1..8");
   end
   if ((1 << SHW) <= WORD_W + DT2) begin : g_bad_shw
      $error("ts_rpll: SHW too narrow for the shift range");
   end

   logic [CW-1:0]  cnt;
   word_t          x_q, ff_q, f_q, y_q, dx_q, ph_r, fr_r;
   logic [SHW-1:0] shf_q, shp_q;
   logic           have_q, vld_r, accept, last;
   dword_t         prod;
   word_t          ff_nx, f_nx;

   assign busy   = (cnt != '0);
   assign accept = upd_stb && !busy;
   assign last   = (cnt == CW'(1));

   ts_rpll_mul #(.W(WORD_W), .STAGES(MUL_STAGES)) i_mul (
      .clk(clk), .rst_n(rst_n), .a(ff_q), .b(dx_q), .p(prod)
   );

   ts_rpll_freq #(.DT2(DT2), .SHW(SHW)) i_freq (
      .prod(prod), .ff(ff_q), .shf(shf_q), .ff_nx(ff_nx)
   );

   ts_rpll_phase #(.DT2(DT2), .SHW(SHW)) i_phase (
      .cap(x_q), .f_old(f_q), .y_adv(y_q), .ff_nx(ff_nx), .shp(shp_q), .f_nx(f_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         x_q    <= '0;
         ff_q   <= '0;
         f_q    <= '0;
         y_q    <= '0;
         dx_q   <= '0;
         shf_q  <= '0;
         shp_q  <= '0;
         have_q <= 1'b0;
         ph_r   <= '0;
         fr_r   <= '0;
         vld_r  <= 1'b0;
      end else begin
         vld_r <= 1'b0;
         if (accept) begin
            cnt    <= CW'(LAT);
            y_q    <= y_q + f_q;
            have_q <= ts_vld;
            if (ts_vld) begin
               dx_q  <= ts_in - x_q;
               x_q   <= ts_in;
               shf_q <= shf_in;
               shp_q <= shp_in;
            end
         end else if (busy) begin
            cnt <= cnt - CW'(1);
            if (last) begin
               vld_r <= 1'b1;
               ph_r  <= y_q;
               if (have_q) begin
                  ff_q <= ff_nx;
                  f_q  <= f_nx;
                  fr_r <= f_nx;
               end else begin
                  fr_r <= f_q;
               end
            end
         end
      end
   end

   assign out_vld = vld_r;
   assign ph_out  = ph_r;
   assign fr_out  = fr_r;

   AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      upd_stb && !busy |=> busy); // R2
   AST_PULSE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> out_vld); // R2
   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |=> !out_vld); // R2
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !out_vld |-> ($stable(ph_out) && $stable(fr_out))); // R11
   AST_NO_TS_FREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld && !have_q |-> fr_out == $past(fr_out)); // R4
   AST_SHIFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      upd_stb && !busy && ts_vld |-> (int'(shf_in) >= DT2) && (int'(shf_in) >= 1)
         && (int'(shf_in) <= WORD_W + DT2) && (int'(shp_in) >= DT2)
         && (int'(shp_in) <= DT2 + 31)); // R6
endmodule

// File: tb/test_ts_rpll.sv
module test_ts_rpll;
   localparam int DT2        = 4;
   localparam int MUL_STAGES = 2;
   localparam int SHW        = 6;
   localparam int LAT        = MUL_STAGES + 1;
   localparam logic [31:0] T0 = 32'hFFFF_F000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic upd_stb = 1'b0;
   logic ts_vld = 1'b0;
   logic [31:0] ts_in = '0;
   logic [SHW-1:0] shf_in = '0;
   logic [SHW-1:0] shp_in = '0;
   logic busy, out_vld;
   logic [31:0] ph_out, fr_out;

   ts_rpll #(.DT2(DT2), .MUL_STAGES(MUL_STAGES), .SHW(SHW)) i_ts_rpll (
      .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .ts_vld(ts_vld), .ts_in(ts_in),
      .shf_in(shf_in), .shp_in(shp_in), .busy(busy), .out_vld(out_vld),
      .ph_out(ph_out), .fr_out(fr_out)
   );

   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // arithmetic model state
   logic [31:0] m_x, m_ff, m_f, m_y;
   logic [31:0] pre_ph, pre_fr;
   int cur_shf, cur_shp;
   longint tick_t, ref_t;
   int jseq;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      m_x = '0; m_ff = '0; m_f = '0; m_y = '0;
   endtask

   task automatic model_step(input bit has, input logic [31:0] c);
      logic [31:0] dx, psig, pref, dt, yref, dy;
      logic [63:0] p;
      logic [64:0] s, sh;
      m_y = m_y + m_f;
      if (has) begin
         dx   = c - m_x;
         m_x  = c;
         p    = {32'b0, m_ff} * {32'b0, dx};
         s    = {1'b0, p} + (65'd1 << (cur_shf - 1));
         sh   = s >> cur_shf;
         psig = sh[31:0];
         pref = (cur_shf <= 32 + DT2) ? 32'(64'd1 << (32 + DT2 - cur_shf)) : 32'd0;
         m_ff = m_ff + pref - psig;
         dt   = (32'd0 - c) & ((32'd1 << DT2) - 32'd1);
         yref = (m_f >> DT2) * dt;
         dy   = 32'($signed(yref - m_y) >>> (cur_shp - DT2));
         m_f  = m_ff + dy;
      end
   endtask

   task automatic do_tick(input bit has, input logic [31:0] c, input bit poke, input string lab);
      @(negedge clk);
      pre_ph = ph_out; pre_fr = fr_out;
      upd_stb = 1'b1; ts_vld = has; ts_in = c;
      shf_in = SHW'(cur_shf); shp_in = SHW'(cur_shp);
      @(negedge clk);
      if (poke) begin
         upd_stb = 1'b1; ts_vld = 1'b1; ts_in = c ^ 32'h5A5A_0F0F;
      end else begin
         upd_stb = 1'b0; ts_vld = 1'b0;
      end
      model_step(has, c);
      chk(busy === 1'b1, "R2 busy after accept", 32'(busy), 32'd1);
      chk(ph_out == pre_ph && fr_out == pre_fr, "R11 hold while busy", fr_out, pre_fr);
      for (int k = 1; k < LAT; k++) begin
         @(negedge clk);
         upd_stb = 1'b0; ts_vld = 1'b0;
         chk(out_vld === 1'b0, "R2 no early pulse", 32'(out_vld), 32'd0);
      end
      @(negedge clk);
      upd_stb = 1'b0; ts_vld = 1'b0;
      chk(out_vld === 1'b1, "R2 pulse at latency", 32'(out_vld), 32'd1);
      chk(fr_out == m_f, {lab, " frequency"}, fr_out, m_f);
      chk(ph_out == m_y, {lab, " phase"}, ph_out, m_y);
      if (poke) begin
         @(negedge clk);
         chk(out_vld === 1'b0 && busy === 1'b0, "R3 busy strobe ignored", 32'(out_vld), 32'd0);
      end
   endtask

   task automatic ref_tick(input int period, input string lab);
      logic [31:0] c;
      int jit;
      tick_t += 16;
      if (ref_t <= tick_t) begin
         jit = ((jseq * 7) % 3) - 1;
         jseq++;
         c = 32'(longint'(T0) + ref_t + jit);
         ref_t += period;
         do_tick(1'b1, c, 1'b0, lab);
      end else begin
         do_tick(1'b0, 32'd0, 1'b0, lab);
      end
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      model_reset();
      chk(ph_out == 0 && fr_out == 0, "R1 outputs zero", fr_out, 32'd0);
      chk(busy === 1'b0 && out_vld === 1'b0, "R1 flags low", 32'({busy, out_vld}), 32'd0);
      rst_n = 1'b1;
      tick_t = 0; ref_t = 8; jseq = 0;
   endtask

   task automatic settle(input int period, input int shf, input int shp);
      longint target, diff;
      cur_shf = shf; cur_shp = shp;
      for (int i = 0; i < 1000; i++) ref_tick(period, "R5");
      target = (longint'(1) << (32 + DT2)) / period;
      diff = longint'(fr_out) - target;
      if (diff < 0) diff = -diff;
      chk(diff * 100 <= target * 3, "R9 settled frequency", fr_out, 32'(target));
   endtask

   initial begin
      model_reset();
      cur_shf = 8; cur_shp = 7;
      apply_reset();

      // first tick without a capture: all zero still
      do_tick(1'b0, 32'd0, 1'b0, "R4");
      chk(fr_out == pre_fr && ph_out == pre_ph + pre_fr, "R4 no capture", ph_out, pre_ph + pre_fr);

      settle(40, 8, 7);

      // tick without capture after lock
      do_tick(1'b0, 32'd0, 1'b0, "R4");
      chk(fr_out == pre_fr, "R4 frequency kept", fr_out, pre_fr);
      chk(ph_out == pre_ph + pre_fr, "R4 phase advance", ph_out, pre_ph + pre_fr);
      tick_t += 16;

      // strobe held into busy window with a bogus capture
      for (int i = 0; i < 4; i++) begin
         tick_t += 16;
         if (ref_t <= tick_t) begin
            do_tick(1'b1, 32'(longint'(T0) + ref_t), 1'b1, "R3");
            ref_t += 40;
         end else begin
            do_tick(1'b0, 32'd0, 1'b1, "R3");
         end
      end

      // capture presented without strobe
      @(negedge clk);
      ts_vld = 1'b1; ts_in = 32'hDEAD_BEEF;
      @(negedge clk);
      ts_vld = 1'b0;
      chk(out_vld === 1'b0 && busy === 1'b0, "R10 no strobe no action", 32'(busy), 32'd0);
      for (int i = 0; i < 6; i++) ref_tick(40, "R10");

      // sweep all legal frequency shifts against several phase shifts
      for (int sf = DT2; sf <= 32 + DT2; sf++) begin
         for (int j = 0; j < 4; j++) begin
            int sp;
            case (j)
               0: sp = DT2;
               1: sp = DT2 + 3;
               2: sp = (sf > DT2) ? sf - 1 : DT2;
               default: sp = DT2 + 31;
            endcase
            cur_shf = sf; cur_shp = sp;
            for (int k = 0; k < 4; k++) ref_tick(40, (sf == DT2) ? "R7" : "R6");
         end
      end
      cur_shf = 8; cur_shp = 7;
      for (int i = 0; i < 10; i++) ref_tick(40, "R8");

      // second configuration after a fresh reset
      apply_reset();
      settle(23, 9, 8);
      for (int i = 0; i < 20; i++) ref_tick(23, "R8");

      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule